// File: doc/BRIEF.md
# Asymmetric SCL Phase Timer

This block sets the timing of the serial clock for a two-wire bus master. It counts system clocks and walks through four phases in a fixed cycle. SCL is driven low in phases 0 and 1 and released high in phases 2 and 3. On the first cycle of every phase it gives a one-cycle strobe together with the phase index. The byte sequencer uses these to place data setup, sampling and hold. The sequencer starts and stops the timer with a single run level.

Two timing modes are available. In the symmetric mode, a 12-bit divider D sets four equal quarters. The first high quarter is lengthened by a fixed input-filter allowance of 15 clocks. In the asymmetric mode, D together with the filter allowance sets the high time, and a separate 12-bit low count sets the low time, so the duty cycle can meet the longer low-time minimum of fast bus modes. The divider reaches the block as two register fields: a 10-bit lower part and a 2-bit extension. All count settings are captured once per SCL period, so software may rewrite them while the bus is running.

Top module: `scl_timing_gen`

## Requirements
- R1: While reset is asserted and after it is released with run low, sclOut is 1, phaseStb is 0 and phaseIdx is 0.
- R2: One clock after run is sampled low, sclOut is 1 and phaseStb stays 0 for as long as run is low. The first clock edge that samples run high starts phase 0 with a strobe, whatever phase was active when the timer stopped.
- R3: While running, phaseIdx steps through 0,1,2,3 and then back to 0. phaseStb is 1 only on the first cycle of each phase. sclOut is 0 in phases 0 and 1 and 1 in phases 2 and 3.
- R4: The 12-bit divider is D = {divExtField[1:0], divLoField[9:0]}. The extension field forms bits 11:10.
- R5: With lowEn = 0, the phase lengths in clocks are Q, Q, Q+15, Q, where Q = D (symmetric mode).
- R6: With lowEn = 1, the low time is split into phase 0 of floor(L/2) clocks and phase 1 of L-floor(L/2) clocks, where L = lowField. Each of the two phases lasts at least one clock.
- R7: With lowEn = 1, phase 2 lasts D+14 clocks and phase 3 lasts 1 clock, so the high time is D+15 clocks.
- R8: A divider of 0 is treated as 1, in both modes. A low count of 0 or 1 gives phases 0 and 1 of one clock each.
- R9: With lowEn = 0, the value of lowField has no effect on any phase length.
- R10: The count settings (divider fields, lowField, lowEn) are sampled on the clock edge that starts phase 0. A change made during a period first takes effect in the following period.
- R11: The largest divider, 4095, gives a symmetric period of 4095, 4095, 4110, 4095 clocks with no wrap of the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| run | input | 1 | Run level from the sequencer; low stops the timer and releases SCL |
| divLoField | input | 10 | Lower 10 bits of the divider |
| divExtField | input | 2 | Upper 2 bits of the divider |
| lowField | input | 12 | Low-time count for the asymmetric mode |
| lowEn | input | 1 | 1 selects the asymmetric mode, 0 the symmetric mode |
| sclOut | output | 1 | SCL level: 0 drives low, 1 releases |
| phaseStb | output | 1 | One-cycle pulse on the first cycle of each phase |
| phaseIdx | output | 2 | Index of the current phase |

## Verification
All three outputs come from registers that are updated on the edge that samples run or a spent counter. The outputs change one edge after run is sampled high or low, and a phase of N clocks shows its strobe on exactly N consecutive samples counted from its own strobe. The bench drives its inputs on the falling clock edge and samples the outputs on the falling edge that follows. It measures each phase as the number of falling-edge samples from one strobe up to the next, so a phase length that is off by even one clock shows up as a mismatch. For the check of mid-period updates, the fields are changed on the sample that shows the phase-0 strobe, which is after the capture edge. The period that is running keeps the old lengths, and the next period shows the new ones.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef logic [1:0] phase_t;

  localparam phase_t PH_FIRST = 2'd0;
  localparam phase_t PH_LAST  = 2'd3;

  // strobes from the phase controller to the count datapath
  typedef struct packed {
    logic   startPeriod;  // capture settings, phase 0 begins
    logic   advance;      // load counter for nextPhase
    phase_t nextPhase;
  } phase_cmd_t;
endpackage

// File: rtl/scl_count_path.sv
module scl_count_path
  import scl_gen_pkg::*;
#(
  parameter int DIV_LO_W    = 10,
  parameter int DIV_EXT_W   = 2,
  parameter int LOW_W       = 12,
  parameter int FILTER_CLKS = 15
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  phase_cmd_t                    cmd,
  input  logic [DIV_LO_W-1:0]           divLoField,
  input  logic [DIV_EXT_W-1:0]          divExtField,
  input  logic [LOW_W-1:0]              lowField,
  input  logic                          lowEn,
  output logic                          cntZero
);
  localparam int DIV_W = DIV_LO_W + DIV_EXT_W;
  localparam int MAX_W = (DIV_W > LOW_W) ? DIV_W : LOW_W;
  localparam int LEN_W = MAX_W + 1;

  logic [DIV_W-1:0] liveDiv, snapDiv, selDiv;
  logic [LOW_W-1:0] snapLow, selLow;
  logic             snapEn, selEn;
  logic [LEN_W-1:0] qLen, lowA, lowB, phaseLen, cnt;
  logic [LOW_W-1:0] lowHalf;

  // R4: divider assembled from the two fields
  assign liveDiv = {divExtField, divLoField};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapDiv <= '0;
      snapLow <= '0;
      snapEn  <= 1'b0;
    end else if (cmd.startPeriod) begin
      snapDiv <= liveDiv;
      snapLow <= lowField;
      snapEn  <= lowEn;
    end
  end

  // phase 0 length uses the values being captured on this edge
  always_comb begin
    if (cmd.startPeriod) begin
      selDiv = liveDiv;
      selLow = lowField;
      selEn  = lowEn;
    end else begin
      selDiv = snapDiv;
      selLow = snapLow;
      selEn  = snapEn;
    end
  end

  always_comb begin
    qLen    = (selDiv == '0) ? LEN_W'(1) : LEN_W'(selDiv);
    lowHalf = selLow >> 1;
    lowA    = (lowHalf == '0) ? LEN_W'(1) : LEN_W'(lowHalf);
    lowB    = ((selLow - lowHalf) == '0) ? LEN_W'(1) : LEN_W'(selLow - lowHalf);
  end

  always_comb begin
    phaseLen = qLen;
    if (selEn) begin
      unique case (cmd.nextPhase)
        2'd0:    phaseLen = lowA;
        2'd1:    phaseLen = lowB;
        2'd2:    phaseLen = qLen + LEN_W'(FILTER_CLKS - 1);
        default: phaseLen = LEN_W'(1);
      endcase
    end else begin
      unique case (cmd.nextPhase)
        2'd2:    phaseLen = qLen + LEN_W'(FILTER_CLKS);
        default: phaseLen = qLen;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 cnt <= '0;
    else if (cmd.advance)      cnt <= phaseLen - LEN_W'(1);
    else if (cnt != '0)        cnt <= cnt - LEN_W'(1);
  end

  assign cntZero = (cnt == '0);

  // R8
  len_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.advance |-> phaseLen != '0);

  // R5
  cnt_decr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.advance && cnt != '0) |=> cnt == $past(cnt) - LEN_W'(1));

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.startPeriod |=> $stable(snapDiv) && $stable(snapLow) && $stable(snapEn));
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       cntZero,
  output phase_cmd_t cmd,
  output logic       sclOut,
  output logic       phaseStb,
  output phase_t     phaseIdx
);
  logic   active;
  phase_t phase;

  always_comb begin
    cmd = '0;
    if (run) begin
      if (!active) begin
        cmd.startPeriod = 1'b1;
        cmd.advance     = 1'b1;
        cmd.nextPhase   = PH_FIRST;
      end else if (cntZero) begin
        cmd.advance     = 1'b1;
        cmd.nextPhase   = phase + 2'd1;
        cmd.startPeriod = (phase == PH_LAST);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      active   <= 1'b0;
      phase    <= PH_FIRST;
      phaseStb <= 1'b0;
    end else begin
      active   <= 1'b1;
      phaseStb <= cmd.advance;
      if (cmd.advance) phase <= cmd.nextPhase;
    end
  end

  assign sclOut   = !active || phase[1];
  assign phaseIdx = phase;

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(run) |=> sclOut && !phaseStb);

  // R2
  stb_needs_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseStb |-> $past(run));

  // R3
  phase_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseStb && $past(active)) |-> phaseIdx == $past(phaseIdx) + 2'd1);

  // R3
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseStb && $past(active) && active) |-> $stable(phaseIdx));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int DIV_LO_W    = 10,
  parameter int DIV_EXT_W   = 2,
  parameter int LOW_W       = 12,
  parameter int FILTER_CLKS = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 run,
  input  logic [DIV_LO_W-1:0]  divLoField,
  input  logic [DIV_EXT_W-1:0] divExtField,
  input  logic [LOW_W-1:0]     lowField,
  input  logic                 lowEn,
  output logic                 sclOut,
  output logic                 phaseStb,
  output logic [1:0]           phaseIdx
);
  phase_cmd_t cmd;
  logic       cntZero;

  scl_phase_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .run      (run),
    .cntZero  (cntZero),
    .cmd      (cmd),
    .sclOut   (sclOut),
    .phaseStb (phaseStb),
    .phaseIdx (phaseIdx)
  );

  scl_count_path #(
    .DIV_LO_W    (DIV_LO_W),
    .DIV_EXT_W   (DIV_EXT_W),
    .LOW_W       (LOW_W),
    .FILTER_CLKS (FILTER_CLKS)
  ) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .cmd         (cmd),
    .divLoField  (divLoField),
    .divExtField (divExtField),
    .lowField    (lowField),
    .lowEn       (lowEn),
    .cntZero     (cntZero)
  );

  // R3
  scl_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phaseStb && phaseIdx == 2'd2) |-> $rose(sclOut));
endmodule

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        run = 1'b0;
  logic [9:0]  divLoField = '0;
  logic [1:0]  divExtField = '0;
  logic [11:0] lowField = '0;
  logic        lowEn = 1'b0;
  logic        sclOut, phaseStb;
  logic [1:0]  phaseIdx;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int lens [4];

  always #4 clk = ~clk;  // 125 MHz

  scl_timing_gen dut (
    .clk(clk), .rstN(rstN), .run(run), .divLoField(divLoField),
    .divExtField(divExtField), .lowField(lowField), .lowEn(lowEn),
    .sclOut(sclOut), .phaseStb(phaseStb), .phaseIdx(phaseIdx)
  );

  typedef struct packed {
    logic [11:0] div;
    logic [11:0] low;
    logic        en;
    logic [12:0] p0, p1, p2, p3;
  } vec_t;

  // div, low, en, expected phase lengths
  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{12'd10,   12'd0,   1'b0, 13'd10,   13'd10,   13'd25,   13'd10},
    '{12'd0,    12'd0,   1'b0, 13'd1,    13'd1,    13'd16,   13'd1},
    '{12'd1030, 12'd0,   1'b0, 13'd1030, 13'd1030, 13'd1045, 13'd1030},
    '{12'd20,   12'd33,  1'b1, 13'd16,   13'd17,   13'd34,   13'd1},
    '{12'd0,    12'd0,   1'b1, 13'd1,    13'd1,    13'd15,   13'd1},
    '{12'd5,    12'd1,   1'b1, 13'd1,    13'd1,    13'd19,   13'd1},
    '{12'd2049, 12'd100, 1'b1, 13'd50,   13'd50,   13'd2063, 13'd1},
    '{12'd4095, 12'd0,   1'b0, 13'd4095, 13'd4095, 13'd4110, 13'd4095},
    '{12'd7,    12'd500, 1'b0, 13'd7,    13'd7,    13'd22,   13'd7}
  };
  localparam string VTAG [NV] = '{"R5 R4", "R8 R5", "R4 R5", "R6 R7",
                                  "R8 R6 R7", "R8 R6", "R4 R6 R7", "R11", "R9"};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  task automatic setCfg(input logic [11:0] d, input logic [11:0] l, input logic e);
    divLoField  = d[9:0];
    divExtField = d[11:10];
    lowField    = l;
    lowEn       = e;
  endtask

  // wait until a sample shows the phase-0 strobe
  task automatic waitPhase0(input string tag);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (phaseStb && phaseIdx == 2'd0) return;
    end
    check(1'b0, {tag, " phase0 not seen"}, 0, 1);
  endtask

  // called on the sample showing the phase-0 strobe; ends on the next one
  task automatic measureHere(input string tag);
    for (int p = 0; p < 4; p++) begin
      int n;
      check(phaseIdx == 2'(p), {tag, " R3 phase index"}, phaseIdx, p);
      check(sclOut == (p >= 2), {tag, " R3 scl level"}, sclOut, p >= 2);
      n = 1;
      for (int k = 0; k < 20000; k++) begin
        @(negedge clk);
        if (phaseStb) break;
        n++;
      end
      lens[p] = n;
    end
  endtask

  task automatic cmpLens(input string tag, input int e0, input int e1, input int e2, input int e3);
    check(lens[0] == e0, {tag, " phase0 len"}, lens[0], e0);
    check(lens[1] == e1, {tag, " phase1 len"}, lens[1], e1);
    check(lens[2] == e2, {tag, " phase2 len"}, lens[2], e2);
    check(lens[3] == e3, {tag, " phase3 len"}, lens[3], e3);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(sclOut == 1'b1, "R1 scl in reset", sclOut, 1);
    check(phaseStb == 1'b0, "R1 stb in reset", phaseStb, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(sclOut == 1'b1 && phaseStb == 1'b0 && phaseIdx == 2'd0,
          "R1 idle after reset", {sclOut, phaseStb, phaseIdx}, 4'b1000);

    // vector table
    for (int v = 0; v < NV; v++) begin
      run = 1'b0;
      setCfg(VEC[v].div, VEC[v].low, VEC[v].en);
      repeat (2) @(negedge clk);
      run = 1'b1;
      waitPhase0(VTAG[v]);
      measureHere(VTAG[v]);
      cmpLens(VTAG[v], VEC[v].p0, VEC[v].p1, VEC[v].p2, VEC[v].p3);
    end

    // R10: change settings inside a running period
    run = 1'b0;
    setCfg(12'd10, 12'd0, 1'b0);
    repeat (2) @(negedge clk);
    run = 1'b1;
    waitPhase0("R10");
    setCfg(12'd20, 12'd0, 1'b0);
    measureHere("R10 old period");
    cmpLens("R10 old period", 10, 10, 25, 10);
    measureHere("R10 new period");
    cmpLens("R10 new period", 20, 20, 35, 20);

    // R2: stop in the middle of phase 2, then restart
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (phaseIdx == 2'd2 && !phaseStb) break;
    end
    run = 1'b0;
    @(negedge clk);
    check(sclOut == 1'b1, "R2 scl released after stop", sclOut, 1);
    check(phaseStb == 1'b0, "R2 no strobe after stop", phaseStb, 0);
    begin
      int seen = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (phaseStb || !sclOut) seen++;
      end
      check(seen == 0, "R2 quiet while stopped", seen, 0);
    end
    run = 1'b1;
    @(negedge clk);
    check(phaseStb == 1'b1 && phaseIdx == 2'd0 && sclOut == 1'b0,
          "R2 restart at phase 0", {phaseStb, phaseIdx, sclOut}, 4'b1000);
    measureHere("R2 restart period");
    cmpLens("R2 restart period", 20, 20, 35, 20);

    run = 1'b0;
    @(negedge clk);
    finishRun();
  end
endmodule